// File: doc/BRIEF.md
# External Interrupt Priority Resolver

This block chooses which of up to 31 external interrupt sources should interrupt the core. Sources are numbered 1 to 31. Each source has a pending input from its gateway, a 4-bit priority register and an enable bit. Among the sources that are both pending and enabled, the block finds the one with the highest effective priority. It then compares that winner against a programmable threshold and against the current priority level, and raises a registered request to the core when the winner beats both.

Software controls the block through a simple word-addressed register bus with a single write strobe and a combinational read port. One configuration bit reverses the priority ordering, so that 0 becomes the most urgent level and 15 the least. The same reversal also applies to how the threshold and the current level are compared. A write to the capture register latches the ID of the source that is currently requesting. Reading that same address returns a handler-address word, which combines a vector table base, the captured ID and two zero bits.

Register map (word addresses):

| Address | Contents |
|---|---|
| 0x01–0x1F | Priority of source n, bits [3:0] |
| 0x21–0x3F | Enable of source n, bit 0 |
| 0x40 | Pending vector (read only) |
| 0x41 | Order select, bit 0 |
| 0x42 | Threshold |
| 0x43 | Current level |
| 0x44 | Claimed-ID level |
| 0x45 | Vector base, bits [31:10] |
| 0x46 | Capture on write; handler word on read |

Any other address reads as 0.

Top module: `ext_irq_resolver`

## Requirements
- R1: After a synchronous active-low reset:
  - every register reads 0;
  - `irq_o` is 0;
  - the handler word reads 0.
- R2: Priority storage and enable storage:
  - A write to word address n (1..31) stores bits [3:0] as the priority of source n, and a read returns them with all upper bits zero.
  - A write to address 0x20+n stores bit 0 as the enable of source n, where 1 means enabled.
- R3: A read of address 0x40 returns the pending inputs as a vector: bit n is the pending input of source n, and bit 0 always reads 0.
- R4: When bit 0 of address 0x41 is 0 (standard order), the winner is the pending, enabled source with the largest priority value.
- R5: When bit 0 of address 0x41 is 1 (reverse order), a smaller value is more urgent, and the threshold and current-level comparisons are reversed in the same way.
- R6: When several candidates share the best effective priority, the lowest source ID wins.
- R7: `irq_o` rises one clock after the winner's effective priority becomes strictly greater than both of these, and falls one clock after it no longer is:
  - the effective threshold (address 0x42);
  - the effective current level (address 0x43).
- R8: A source whose priority is 0 in standard order, or 15 in reverse order, never causes a request and is never captured.
- R9: Capture behaviour:
  - Any write to address 0x46 latches the ID of the source that is requesting in that cycle, or 0 if no request condition holds.
  - The pending inputs seen in that same cycle are the ones used.
  - The captured ID changes on no other event.
- R10: A read of address 0x46 returns the handler word:
  - bits [31:10] hold the vector base written to address 0x45 (bits [31:10] of the write data);
  - bits [9:2] hold the captured ID;
  - bits [1:0] are 0.
- R11: The current level (0x43) and the claimed-ID level (0x44) are 4-bit read/write registers, and they ignore upper write bits.
- R12: A disabled source is never chosen, even when it is pending and has the best priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_in | input | NUM_SRC+1 | Gateway pending flags; bit n belongs to source n, bit 0 unused |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Registered interrupt request to the core |

## Verification
A capture write and a change of the pending inputs can land in the same clock cycle. The latched ID must then reflect the pending set of that very cycle, while `irq_o` still shows the previous cycle's decision. The bench provokes this by dropping the current winner's pending bit in the same cycle as the capture strobe. It judges the result by reading the handler word back and by checking that a later pending change with no capture leaves that word unchanged. A second collision, an order flip that changes both the winner and the threshold meaning at once, is covered by the reverse-order checks.

// File: rtl/eipr_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, register addresses and the ordering helper for the
// external interrupt priority resolver. Assumes at most 31 sources.
package eipr_pkg;
    localparam int PRIO_W = 4;
    localparam int ID_W   = 8;
    localparam int BASE_W = 22;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 7;

    localparam logic [ADDR_W-1:0] A_PEND = 7'h40;
    localparam logic [ADDR_W-1:0] A_CFG  = 7'h41;
    localparam logic [ADDR_W-1:0] A_THR  = 7'h42;
    localparam logic [ADDR_W-1:0] A_CUR  = 7'h43;
    localparam logic [ADDR_W-1:0] A_CLPL = 7'h44;
    localparam logic [ADDR_W-1:0] A_BASE = 7'h45;
    localparam logic [ADDR_W-1:0] A_CAPT = 7'h46;

    typedef logic [PRIO_W-1:0] prio_t;

    // Map a raw level onto a scale where a larger value is always more urgent.
    function automatic prio_t eff_of(prio_t p, logic rev);
        return rev ? ~p : p;
    endfunction
endpackage

// File: rtl/eipr_regs.sv
`timescale 1ns/1ps
// Module: register file and read mux. Holds the per-source priority and enable
// fields, the control registers and the captured claim ID.
// Assumes NUM_SRC <= 31; bank is selected by address bits [6:5].
module eipr_regs
    import eipr_pkg::*;
#(
    parameter int NUM_SRC = 31
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic [NUM_SRC:0]      pend_in,
    input  logic [ID_W-1:0]       cap_id,
    output prio_t [NUM_SRC:0]     prio,
    output logic [NUM_SRC:0]      en,
    output logic                  rev,
    output prio_t                 thr,
    output prio_t                 cur,
    output logic [DATA_W-1:0]     bus_rdata
);
    localparam int IDX_W = 5;

    logic [IDX_W-1:0]  idx;
    logic [1:0]        bank;
    prio_t             clpl;
    logic [BASE_W-1:0] base;
    logic [ID_W-1:0]   claim_id;
    logic              cap_wr;

    assign idx    = bus_addr[IDX_W-1:0];
    assign bank   = bus_addr[ADDR_W-1:IDX_W];
    assign cap_wr = bus_wr && (bus_addr == A_CAPT);

    assign prio[0] = '0;
    assign en[0]   = 1'b0;

    for (genvar n = 1; n <= NUM_SRC; n++) begin : g_src
        // Per-source priority and enable storage.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio[n] <= '0;
                en[n]   <= 1'b0;
            end else if (bus_wr && idx == IDX_W'(n)) begin
                if (bank == 2'd0) prio[n] <= bus_wdata[PRIO_W-1:0];
                if (bank == 2'd1) en[n]   <= bus_wdata[0];
            end
        end
    end

    // Control registers: order select, threshold, levels, vector base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rev  <= 1'b0;
            thr  <= '0;
            cur  <= '0;
            clpl <= '0;
            base <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_CFG:   rev  <= bus_wdata[0];
                A_THR:   thr  <= bus_wdata[PRIO_W-1:0];
                A_CUR:   cur  <= bus_wdata[PRIO_W-1:0];
                A_CLPL:  clpl <= bus_wdata[PRIO_W-1:0];
                A_BASE:  base <= bus_wdata[DATA_W-1:DATA_W-BASE_W];
                default: ;
            endcase
        end
    end

    // Claim ID latch, updated only by a capture write.
    always_ff @(posedge clk) begin
        if (!rst_n)      claim_id <= '0;
        else if (cap_wr) claim_id <= cap_id;
    end

    // Combinational read mux.
    always_comb begin
        bus_rdata = '0;
        if (bank == 2'd0 && int'(idx) >= 1 && int'(idx) <= NUM_SRC)
            bus_rdata[PRIO_W-1:0] = prio[idx];
        else if (bank == 2'd1 && int'(idx) >= 1 && int'(idx) <= NUM_SRC)
            bus_rdata[0] = en[idx];
        else begin
            case (bus_addr)
                A_PEND:  bus_rdata[NUM_SRC:0] = pend_in & ~(NUM_SRC+1)'(1);
                A_CFG:   bus_rdata[0] = rev;
                A_THR:   bus_rdata[PRIO_W-1:0] = thr;
                A_CUR:   bus_rdata[PRIO_W-1:0] = cur;
                A_CLPL:  bus_rdata[PRIO_W-1:0] = clpl;
                A_BASE:  bus_rdata[DATA_W-1:DATA_W-BASE_W] = base;
                A_CAPT:  bus_rdata = {base, claim_id, 2'b00};
                default: bus_rdata = '0;
            endcase
        end
    end

    // R9: the captured ID never names a source that does not exist.
    assert_claim_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        claim_id <= ID_W'(NUM_SRC));
    // R9: without a capture write the claim ID holds its value.
    assert_claim_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_wr |=> $stable(claim_id));
endmodule

// File: rtl/eipr_arbiter.sv
`timescale 1ns/1ps
// Module: finds the pending, enabled source with the highest effective
// priority. Ties go to the lowest ID; effective priority 0 never wins.
// Assumes en[0] is tied low, so slot 0 is never a candidate.
module eipr_arbiter
    import eipr_pkg::*;
#(
    parameter int NUM_SRC = 31
) (
    input  prio_t [NUM_SRC:0] prio,
    input  logic  [NUM_SRC:0] pend,
    input  logic  [NUM_SRC:0] en,
    input  logic              rev,
    output logic  [ID_W-1:0]  win_id,
    output prio_t             win_eff
);
    prio_t [NUM_SRC:0] eff;

    for (genvar n = 0; n <= NUM_SRC; n++) begin : g_eff
        assign eff[n] = (pend[n] && en[n]) ? eff_of(prio[n], rev) : '0;
    end

    // Ascending scan; a strict compare keeps the lowest ID on a tie.
    always_comb begin
        win_eff = '0;
        win_id  = '0;
        for (int n = 0; n <= NUM_SRC; n++) begin
            if (eff[n] > win_eff) begin
                win_eff = eff[n];
                win_id  = ID_W'(n);
            end
        end
    end
endmodule

// File: rtl/eipr_gate.sv
`timescale 1ns/1ps
// Module: compares the winner against threshold and current level in the
// selected order; drives the registered request and the capture ID.
// Assumes the arbiter reports effective priority 0 when there is no winner.
module eipr_gate
    import eipr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] win_id,
    input  prio_t           win_eff,
    input  prio_t           thr,
    input  prio_t           cur,
    input  logic            rev,
    output logic [ID_W-1:0] req_id,
    output logic            irq_o
);
    logic fire;

    assign fire   = (win_eff > eff_of(thr, rev)) && (win_eff > eff_of(cur, rev));
    assign req_id = fire ? win_id : '0;

    // Request register toward the core.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= fire;
    end

    // R7: a request implies the winner beat the current level one cycle earlier.
    assert_irq_above_cur_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(win_eff > eff_of(cur, rev)));
endmodule

// File: rtl/ext_irq_resolver.sv
`timescale 1ns/1ps
// Module: top of the external interrupt priority resolver. Connects the
// register file, the arbiter and the request gate.
// Assumes NUM_SRC <= 31 and a single-cycle register bus.
module ext_irq_resolver
    import eipr_pkg::*;
#(
    parameter int NUM_SRC = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC:0]  pend_in,
    input  logic              bus_wr,
    input  logic [6:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);
    localparam int IDX_W = $clog2(NUM_SRC + 1);

    prio_t [NUM_SRC:0] prio;
    logic  [NUM_SRC:0] en;
    logic              rev;
    prio_t             thr;
    prio_t             cur;
    logic [ID_W-1:0]   win_id;
    prio_t             win_eff;
    logic [ID_W-1:0]   req_id;

    eipr_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .pend_in(pend_in), .cap_id(req_id),
        .prio(prio), .en(en), .rev(rev), .thr(thr), .cur(cur),
        .bus_rdata(bus_rdata)
    );

    eipr_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .prio(prio), .pend(pend_in), .en(en), .rev(rev),
        .win_id(win_id), .win_eff(win_eff)
    );

    eipr_gate u_gate (
        .clk(clk), .rst_n(rst_n), .win_id(win_id), .win_eff(win_eff),
        .thr(thr), .cur(cur), .rev(rev), .req_id(req_id), .irq_o(irq_o)
    );

    // R12: a named winner is always pending and enabled.
    assert_win_enabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (win_id != '0) |-> (pend_in[win_id[IDX_W-1:0]] && en[win_id[IDX_W-1:0]]));
    // R7: a request implies the winner beat the threshold one cycle earlier.
    assert_irq_above_thr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(win_eff > eff_of(thr, rev)));
    // R8: a masked level never produces a request.
    assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(prio[win_id[IDX_W-1:0]] != (rev ? 4'hF : 4'h0)));
endmodule

// File: tb/ext_irq_resolver_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected values, and a monitor compares
// them against the DUT outputs at the falling edge.
module ext_irq_resolver_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pend_in = '0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sbq[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    localparam logic [31:0] HB = 32'hABCDE400;

    always #5 clk = ~clk;

    ext_irq_resolver #(.NUM_SRC(31)) u_dut (
        .clk(clk), .rst_n(rst_n), .pend_in(pend_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o)
    );

    // Monitor: pop expected items and compare at the falling edge.
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sbq.pop_front();
            act = it.is_irq ? {31'b0, irq_o} : bus_rdata;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic exp_rd(input logic [6:0] a, input logic [31:0] v, input string tag);
        @(posedge clk); #1;
        bus_addr = a;
        sbq.push_back('{1'b0, v, tag});
        @(negedge clk);
    endtask

    task automatic exp_irq(input bit v, input string tag);
        @(posedge clk); #1;
        sbq.push_back('{1'b1, {31'b0, v}, tag});
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        exp_irq(0, "R1 irq");
        exp_rd(7'h41, 0, "R1 order");
        exp_rd(7'h42, 0, "R1 threshold");
        exp_rd(7'h46, 0, "R1 handler");
        exp_rd(7'h03, 0, "R1 prio");
        exp_rd(7'h23, 0, "R1 enable");
        // R3 pending vector, bit 0 masked
        pend_in = 32'h0000_0089;
        exp_rd(7'h40, 32'h88, "R3 pending");
        // R2 storage
        wr(7'h03, 32'h5A);
        exp_rd(7'h03, 32'hA, "R2 prio");
        wr(7'h23, 32'hFF);
        exp_rd(7'h23, 32'h1, "R2 enable");
        // R7 request, R9 capture
        exp_irq(1, "R7 raise");
        wr(7'h46, 0);
        exp_rd(7'h46, 32'h0C, "R9 capture");
        // R10 handler word
        wr(7'h45, 32'hABCDE7FF);
        exp_rd(7'h46, HB | 32'h0C, "R10 handler");
        // R4 standard order
        wr(7'h07, 12); wr(7'h27, 1); wr(7'h46, 0);
        exp_rd(7'h46, HB | 32'h1C, "R4 higher wins");
        // R6 tie
        wr(7'h07, 10); wr(7'h46, 0);
        exp_rd(7'h46, HB | 32'h0C, "R6 tie lower id");
        // R12 disabled source ignored
        wr(7'h23, 0); wr(7'h46, 0);
        exp_rd(7'h46, HB | 32'h1C, "R12 disabled");
        wr(7'h23, 1);
        // R7 threshold and current level
        wr(7'h42, 10);
        exp_irq(0, "R7 thr equal");
        wr(7'h46, 0);
        exp_rd(7'h46, HB, "R9 no request id 0");
        wr(7'h42, 9);
        exp_irq(1, "R7 thr below");
        wr(7'h43, 10);
        exp_irq(0, "R7 cur equal");
        wr(7'h43, 9);
        exp_irq(1, "R7 cur below");
        wr(7'h42, 0); wr(7'h43, 0);
        // R11 level registers
        wr(7'h44, 32'h37);
        exp_rd(7'h44, 7, "R11 claimed level");
        wr(7'h43, 32'h25);
        exp_rd(7'h43, 5, "R11 current level");
        wr(7'h43, 0);
        // R8 standard masking
        wr(7'h03, 0); wr(7'h07, 0);
        exp_irq(0, "R8 std masked");
        wr(7'h46, 0);
        exp_rd(7'h46, HB, "R8 std not captured");
        // R5 reverse order
        wr(7'h41, 1);
        exp_rd(7'h41, 1, "R5 order bit");
        exp_irq(0, "R5 threshold 0 blocks");
        wr(7'h42, 15); wr(7'h43, 15);
        exp_irq(1, "R5 level 0 urgent");
        wr(7'h03, 4); wr(7'h07, 2); wr(7'h46, 0);
        exp_rd(7'h46, HB | 32'h1C, "R5 lower value wins");
        // R8 reverse masking
        wr(7'h03, 15); wr(7'h07, 15);
        exp_irq(0, "R8 rev masked");
        wr(7'h46, 0);
        exp_rd(7'h46, HB, "R8 rev not captured");
        // R6 reverse tie
        wr(7'h03, 6); wr(7'h07, 6); wr(7'h46, 0);
        exp_rd(7'h46, HB | 32'h0C, "R6 rev tie");
        // R9 capture in the same cycle as a pending drop
        wr(7'h07, 3); wr(7'h46, 0);
        exp_rd(7'h46, HB | 32'h1C, "R9 before drop");
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = 7'h46; pend_in = 32'h08;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        exp_rd(7'h46, HB | 32'h0C, "R9 same-cycle drop");
        pend_in = 32'h88;
        repeat (2) @(posedge clk);
        exp_rd(7'h46, HB | 32'h0C, "R9 hold without capture");
        exp_irq(1, "R7 still requesting");
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        #(20000 * 10);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule